// File: doc/BRIEF.md
# Trap Entry and Return Controller

This block sits beside the execute stage of a small 32-bit RISC core and turns trap requests into control-flow redirects. The pipeline raises one or more of four request lines (data bus error, divide by zero, system call, breakpoint) together with the PC of the faulting instruction. The block picks one request by fixed priority and selects the link register that receives the faulting PC. It folds the live interrupt-enable bit into a saved slot and produces the handler address from a per-class base register. All of these results are registered and appear one clock after the request.

The block also restores interrupt enable when the core branches back through either link register. It holds the four control registers it needs: interrupt enable, pending interrupts, the exception base and the debug base. The core's CSR write port writes these registers. The pending register is write-one-to-clear, and its bits are set by pulses from the interrupt source logic.

Top module: `trap_ctrl`

## Requirements
- R1: A winning data bus error, divide-by-zero or system call request causes, one clock later, a single-cycle `rf_we_o` with `rf_waddr_o` = 30 and `rf_wdata_o` equal to the requesting `trap_pc_i`.
- R2: A winning breakpoint request causes the same write one clock later, but with `rf_waddr_o` = 31.
- R3: `ie_o` bit 0 is the live enable, bit 1 the value saved by a normal trap, and bit 2 the value saved by a breakpoint. A normal trap sets `ie_o` to the old bit 0 in bit 1, with bits 0 and 2 cleared.
- R4: A breakpoint sets `ie_o` to the old bit 0 in bit 2, with bits 0 and 1 cleared.
- R5: Together with the write, `redirect_o` pulses and `redirect_pc_o` = base + 32 × ID, where the IDs are breakpoint 1, data bus error 4, divide by zero 5 and system call 7, shown on `exc_id_o`. The base is the debug base for a breakpoint and the exception base for the other three.
- R6: `ret_i` with `ret_reg_i` = 30 sets `ie_o` to {0,0,old bit 1}, and with `ret_reg_i` = 31 to {0,0,old bit 2}, on the next clock. With any other register number it has no effect.
- R7: `csr_we_i` writes the register chosen by `csr_sel_i`: 0 interrupt enable, taking `csr_wdata_i[2:0]`; 1 pending; 2 exception base; 3 debug base.
- R8: A pending write clears each `ip_o` bit whose data bit is 1 and leaves the other bits alone. A bit set by `irq_set_i` in the same cycle stays set.
- R9: The exception base and debug base store `csr_wdata_i` with bits 7:0 forced to zero.
- R10: When several requests are raised in one cycle, the winner is data bus error, then divide by zero, then system call, then breakpoint.
- R11: In a cycle with a trap request, `ret_i` and `csr_we_i` are ignored. In a cycle with a restoring return (register 30 or 31), `csr_we_i` is ignored.
- R12: After reset, `ie_o`, `ip_o`, `eba_o`, `deba_o`, `redirect_o` and `rf_we_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| trap_dbe_i | input | 1 | Data bus error request (unmapped or misaligned access) |
| trap_dz_i | input | 1 | Divide-by-zero request |
| trap_sc_i | input | 1 | System call request |
| trap_bp_i | input | 1 | Breakpoint request |
| trap_pc_i | input | 32 | PC of the faulting instruction |
| ret_i | input | 1 | Register-indirect branch is executing |
| ret_reg_i | input | 5 | Register number that branch goes through |
| csr_we_i | input | 1 | CSR write strobe |
| csr_sel_i | input | 2 | CSR select (0 IE, 1 IP, 2 EBA, 3 DEBA) |
| csr_wdata_i | input | 32 | CSR write data |
| irq_set_i | input | 32 | Pending-bit set pulses |
| redirect_o | output | 1 | Fetch redirect pulse |
| redirect_pc_o | output | 32 | Handler address |
| exc_id_o | output | 3 | ID of the trap taken |
| rf_we_o | output | 1 | Link register write strobe |
| rf_waddr_o | output | 5 | Link register number |
| rf_wdata_o | output | 32 | Saved faulting PC |
| ie_o | output | 3 | Interrupt enable register |
| ip_o | output | 32 | Pending interrupt register |
| eba_o | output | 32 | Exception base |
| deba_o | output | 32 | Debug base |

## Verification
The checker watches every cycle for the following. Link register choice and saved PC must match the trap class. The saved-enable shuffle on trap and on return must match. The handler address must match the base and ID. Priority must hold when requests collide. The pending register may only be cleared bit by bit, and the base low bits must stay zero. The directed scenarios are needed for the rest: concrete handler addresses after real base writes, a trap-then-return round trip, returns through other registers leaving the enable untouched, and CSR writes being dropped in a trap cycle.

// File: rtl/trap_pkg.sv
// Shared types for the trap controller: exception IDs, CSR selects and
// the link register numbers. Assumes 32-byte handler slots.
package trap_pkg;
    typedef enum logic [2:0] {
        EID_RESET = 3'd0,
        EID_BREAK = 3'd1,
        EID_IBUS  = 3'd2,
        EID_WATCH = 3'd3,
        EID_DBUS  = 3'd4,
        EID_DIVZ  = 3'd5,
        EID_IRQ   = 3'd6,
        EID_SCALL = 3'd7
    } eid_t;

    typedef enum logic [1:0] {
        CSEL_IE   = 2'd0,
        CSEL_IP   = 2'd1,
        CSEL_EBA  = 2'd2,
        CSEL_DEBA = 2'd3
    } csel_t;

    localparam logic [4:0] LINK_EXC = 5'd30;
    localparam logic [4:0] LINK_BRK = 5'd31;
    localparam int unsigned SLOT_SHIFT = 5;
    localparam int unsigned NUM_REQ = 4;
endpackage

// File: rtl/trap_arbiter.sv
// Fixed-priority pick among trap requests. req[0] is the highest priority.
// The order is data bus error, divide by zero, system call, breakpoint.
// Purely combinational; assumes NUM_REQ matches the ID table below.
module trap_arbiter
    import trap_pkg::*;
(
    input  logic [NUM_REQ-1:0] req,
    output logic               valid,
    output eid_t               id,
    output logic               is_brk
);
    // Maps a request position to its exception ID.
    function automatic eid_t id_of(input int unsigned idx);
        case (idx)
            0:       return EID_DBUS;
            1:       return EID_DIVZ;
            2:       return EID_SCALL;
            default: return EID_BREAK;
        endcase
    endfunction

    // Scans from lowest to highest priority so the highest one wins last.
    always_comb begin
        valid = 1'b0;
        id    = EID_RESET;
        for (int i = NUM_REQ - 1; i >= 0; i--) begin
            if (req[i]) begin
                valid = 1'b1;
                id    = id_of(i);
            end
        end
        is_brk = valid && (id == EID_BREAK);
    end
endmodule

// File: rtl/trap_csr_regs.sv
// Interrupt enable, pending, exception base and debug base registers.
// Trap entry and return update IE. The caller resolves precedence, so at
// most one of trap_take, ret_take and csr_we is set in a cycle.
// Pending bits are set by pulses and cleared by write-one.
module trap_csr_regs
    import trap_pkg::*;
#(
    parameter int unsigned XLEN       = 32,
    parameter int unsigned IRQ_W      = 32,
    parameter int unsigned ALIGN_BITS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trap_take,
    input  logic             trap_brk,
    input  logic             ret_take,
    input  logic             ret_brk,
    input  logic             csr_we,
    input  csel_t            csr_sel,
    input  logic [XLEN-1:0]  csr_wdata,
    input  logic [IRQ_W-1:0] irq_set,
    output logic [2:0]       ie,
    output logic [IRQ_W-1:0] ip,
    output logic [XLEN-1:0]  eba,
    output logic [XLEN-1:0]  deba
);
    localparam int unsigned BASE_W = XLEN - ALIGN_BITS;

    logic [2:0]       ie_n;
    logic [IRQ_W-1:0] ip_n;
    logic [IRQ_W-1:0] clr_mask;

    // Next IE: the trap shuffle, the return restore, or a direct write.
    always_comb begin
        ie_n = ie;
        if (trap_take) begin
            ie_n = trap_brk ? {ie[0], 2'b00} : {1'b0, ie[0], 1'b0};
        end else if (ret_take) begin
            ie_n = ret_brk ? {2'b00, ie[2]} : {2'b00, ie[1]};
        end else if (csr_we && csr_sel == CSEL_IE) begin
            ie_n = csr_wdata[2:0];
        end
    end

    // Next IP: write-one-to-clear, with new set pulses taking precedence.
    always_comb begin
        clr_mask = (csr_we && csr_sel == CSEL_IP) ? csr_wdata[IRQ_W-1:0] : '0;
        ip_n     = (ip & ~clr_mask) | irq_set;
    end

    // State update for IE and IP.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie <= '0;
            ip <= '0;
        end else begin
            ie <= ie_n;
            ip <= ip_n;
        end
    end

    // Base registers keep only the bits above the slot alignment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eba  <= '0;
            deba <= '0;
        end else if (csr_we) begin
            if (csr_sel == CSEL_EBA)
                eba <= {csr_wdata[XLEN-1 -: BASE_W], {ALIGN_BITS{1'b0}}};
            if (csr_sel == CSEL_DEBA)
                deba <= {csr_wdata[XLEN-1 -: BASE_W], {ALIGN_BITS{1'b0}}};
        end
    end
endmodule

// File: rtl/trap_ctrl.sv
// Trap entry and return controller. Picks one trap request by priority,
// then registers the link-register write, the handler address and the ID.
// The result appears one clock after the request. A trap cycle drops any
// return or CSR write; a restoring return drops a CSR write.
// Assumes ALIGN_BITS covers the 8 slots of 32 bytes.
module trap_ctrl
    import trap_pkg::*;
#(
    parameter int unsigned XLEN       = 32,
    parameter int unsigned IRQ_W      = 32,
    parameter int unsigned ALIGN_BITS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trap_dbe_i,
    input  logic             trap_dz_i,
    input  logic             trap_sc_i,
    input  logic             trap_bp_i,
    input  logic [XLEN-1:0]  trap_pc_i,
    input  logic             ret_i,
    input  logic [4:0]       ret_reg_i,
    input  logic             csr_we_i,
    input  logic [1:0]       csr_sel_i,
    input  logic [XLEN-1:0]  csr_wdata_i,
    input  logic [IRQ_W-1:0] irq_set_i,
    output logic             redirect_o,
    output logic [XLEN-1:0]  redirect_pc_o,
    output logic [2:0]       exc_id_o,
    output logic             rf_we_o,
    output logic [4:0]       rf_waddr_o,
    output logic [XLEN-1:0]  rf_wdata_o,
    output logic [2:0]       ie_o,
    output logic [IRQ_W-1:0] ip_o,
    output logic [XLEN-1:0]  eba_o,
    output logic [XLEN-1:0]  deba_o
);
    localparam int unsigned MIN_ALIGN = SLOT_SHIFT + 3;

    // Elaboration-time guard on the parameter relationships.
    generate
        if (ALIGN_BITS < MIN_ALIGN || IRQ_W > XLEN) begin : g_bad_cfg
            initial $error("trap_ctrl: ALIGN_BITS or IRQ_W out of range");
        end
    endgenerate

    logic [NUM_REQ-1:0] req;
    logic               trap_valid;
    eid_t               trap_id;
    logic               trap_brk;
    logic               ret_hit;
    logic               ret_brk;
    logic               ret_take;
    logic               csr_take;
    logic [XLEN-1:0]    vec_base;
    logic [XLEN-1:0]    vec_addr;

    // Request vector in priority order, highest first.
    assign req = {trap_bp_i, trap_sc_i, trap_dz_i, trap_dbe_i};

    trap_arbiter u_arb (
        .req    (req),
        .valid  (trap_valid),
        .id     (trap_id),
        .is_brk (trap_brk)
    );

    // Resolve returns and CSR writes against a concurrent trap.
    always_comb begin
        ret_brk  = (ret_reg_i == LINK_BRK);
        ret_hit  = ret_i && ((ret_reg_i == LINK_EXC) || ret_brk);
        ret_take = ret_hit && !trap_valid;
        csr_take = csr_we_i && !trap_valid && !ret_take;
    end

    trap_csr_regs #(
        .XLEN       (XLEN),
        .IRQ_W      (IRQ_W),
        .ALIGN_BITS (ALIGN_BITS)
    ) u_csr (
        .clk       (clk),
        .rst_n     (rst_n),
        .trap_take (trap_valid),
        .trap_brk  (trap_brk),
        .ret_take  (ret_take),
        .ret_brk   (ret_brk),
        .csr_we    (csr_take),
        .csr_sel   (csel_t'(csr_sel_i)),
        .csr_wdata (csr_wdata_i),
        .irq_set   (irq_set_i),
        .ie        (ie_o),
        .ip        (ip_o),
        .eba       (eba_o),
        .deba      (deba_o)
    );

    // Handler address: class base plus the ID scaled to a slot.
    always_comb begin
        vec_base = trap_brk ? deba_o : eba_o;
        vec_addr = vec_base + (XLEN'(trap_id) << SLOT_SHIFT);
    end

    // Registered redirect and link write; the pulses last one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            redirect_o    <= 1'b0;
            rf_we_o       <= 1'b0;
            redirect_pc_o <= '0;
            exc_id_o      <= EID_RESET;
            rf_waddr_o    <= '0;
            rf_wdata_o    <= '0;
        end else begin
            redirect_o <= trap_valid;
            rf_we_o    <= trap_valid;
            if (trap_valid) begin
                redirect_pc_o <= vec_addr;
                exc_id_o      <= trap_id;
                rf_waddr_o    <= trap_brk ? LINK_BRK : LINK_EXC;
                rf_wdata_o    <= trap_pc_i;
            end
        end
    end
endmodule

// File: rtl/trap_ctrl_chk.sv
// Cycle-by-cycle properties of trap_ctrl, attached by bind below.
// Sees only the top-level ports.
module trap_ctrl_chk #(
    parameter int unsigned XLEN       = 32,
    parameter int unsigned IRQ_W      = 32,
    parameter int unsigned ALIGN_BITS = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             trap_dbe_i,
    input logic             trap_dz_i,
    input logic             trap_sc_i,
    input logic             trap_bp_i,
    input logic [XLEN-1:0]  trap_pc_i,
    input logic             ret_i,
    input logic [4:0]       ret_reg_i,
    input logic             csr_we_i,
    input logic [1:0]       csr_sel_i,
    input logic [XLEN-1:0]  csr_wdata_i,
    input logic [IRQ_W-1:0] irq_set_i,
    input logic             redirect_o,
    input logic [XLEN-1:0]  redirect_pc_o,
    input logic [2:0]       exc_id_o,
    input logic             rf_we_o,
    input logic [4:0]       rf_waddr_o,
    input logic [XLEN-1:0]  rf_wdata_o,
    input logic [2:0]       ie_o,
    input logic [IRQ_W-1:0] ip_o,
    input logic [XLEN-1:0]  eba_o,
    input logic [XLEN-1:0]  deba_o
);
    logic any_trap;
    assign any_trap = trap_dbe_i | trap_dz_i | trap_sc_i | trap_bp_i;

    assert_link_exc_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (any_trap && !(trap_bp_i && !trap_dbe_i && !trap_dz_i && !trap_sc_i))
        |=> rf_we_o && rf_waddr_o == 5'd30 && rf_wdata_o == $past(trap_pc_i));

    assert_link_brk_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_bp_i && !trap_dbe_i && !trap_dz_i && !trap_sc_i)
        |=> rf_we_o && rf_waddr_o == 5'd31 && rf_wdata_o == $past(trap_pc_i));

    assert_ie_exc_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect_o && exc_id_o != 3'd1) |-> ie_o == {1'b0, $past(ie_o[0]), 1'b0});

    assert_ie_brk_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect_o && exc_id_o == 3'd1) |-> ie_o == {$past(ie_o[0]), 2'b00});

    assert_vector_R5: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_o |-> redirect_pc_o ==
            ((exc_id_o == 3'd1) ? deba_o : eba_o) + ({{(XLEN-3){1'b0}}, exc_id_o} << 5));

    assert_ret_exc_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_i && ret_reg_i == 5'd30 && !any_trap) |=> ie_o == {2'b00, $past(ie_o[1])});

    assert_ret_brk_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_i && ret_reg_i == 5'd31 && !any_trap) |=> ie_o == {2'b00, $past(ie_o[2])});

    assert_ip_w1c_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_set_i == '0) |=> (ip_o & ~$past(ip_o)) == '0);

    assert_base_align_R9: assert property (@(posedge clk) disable iff (!rst_n)
        eba_o[ALIGN_BITS-1:0] == '0 && deba_o[ALIGN_BITS-1:0] == '0);

    assert_prio_dbe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        trap_dbe_i |=> exc_id_o == 3'd4);

    assert_prio_dz_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_dz_i && !trap_dbe_i) |=> exc_id_o == 3'd5);

    assert_trap_blocks_R11: assert property (@(posedge clk) disable iff (!rst_n)
        any_trap |=> $stable(eba_o) && $stable(deba_o));

    assert_single_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!any_trap) |-> !redirect_o && !rf_we_o);
endmodule

bind trap_ctrl trap_ctrl_chk #(
    .XLEN       (XLEN),
    .IRQ_W      (IRQ_W),
    .ALIGN_BITS (ALIGN_BITS)
) u_chk (.*);

// File: tb/trap_ctrl_test.sv
// Directed bench for trap_ctrl: one task per scenario, each self-checking.
module trap_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        trap_dbe_i, trap_dz_i, trap_sc_i, trap_bp_i;
    logic [31:0] trap_pc_i;
    logic        ret_i;
    logic [4:0]  ret_reg_i;
    logic        csr_we_i;
    logic [1:0]  csr_sel_i;
    logic [31:0] csr_wdata_i;
    logic [31:0] irq_set_i;
    logic        redirect_o;
    logic [31:0] redirect_pc_o;
    logic [2:0]  exc_id_o;
    logic        rf_we_o;
    logic [4:0]  rf_waddr_o;
    logic [31:0] rf_wdata_o;
    logic [2:0]  ie_o;
    logic [31:0] ip_o;
    logic [31:0] eba_o;
    logic [31:0] deba_o;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    trap_ctrl uut (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        trap_dbe_i = 0; trap_dz_i = 0; trap_sc_i = 0; trap_bp_i = 0;
        trap_pc_i = '0; ret_i = 0; ret_reg_i = '0;
        csr_we_i = 0; csr_sel_i = '0; csr_wdata_i = '0; irq_set_i = '0;
    endtask

    // Drive one cycle of stimulus from a negedge; outputs are valid at the next negedge.
    task automatic step();
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic csr_wr(input logic [1:0] sel, input logic [31:0] d);
        csr_we_i = 1; csr_sel_i = sel; csr_wdata_i = d;
        step();
    endtask

    task automatic trap(input logic dbe, dz, sc, bp, input logic [31:0] pc);
        trap_dbe_i = dbe; trap_dz_i = dz; trap_sc_i = sc; trap_bp_i = bp; trap_pc_i = pc;
        step();
    endtask

    task automatic ret(input logic [4:0] r);
        ret_i = 1; ret_reg_i = r;
        step();
    endtask

    task automatic t_reset();
        chk("R12 ie", 32'(ie_o), 0);
        chk("R12 ip", ip_o, 0);
        chk("R12 eba", eba_o, 0);
        chk("R12 deba", deba_o, 0);
        chk("R12 redirect", 32'({redirect_o, rf_we_o}), 0);
    endtask

    task automatic t_csr_writes();
        csr_wr(2'd2, 32'h1234_5678);
        chk("R9 eba align", eba_o, 32'h1234_5600);
        csr_wr(2'd3, 32'hABCD_EFFF);
        chk("R9 deba align", deba_o, 32'hABCD_EF00);
        csr_wr(2'd0, 32'hFFFF_FFF9);
        chk("R7 ie write", 32'(ie_o), 1);
    endtask

    task automatic t_syscall_and_return();
        trap(0, 0, 1, 0, 32'h0000_0100);
        chk("R1 we/addr", 32'({rf_we_o, rf_waddr_o}), 32'({1'b1, 5'd30}));
        chk("R1 saved pc", rf_wdata_o, 32'h0000_0100);
        chk("R5 sc vector", redirect_pc_o, 32'h1234_56E0);
        chk("R5 sc id", 32'(exc_id_o), 7);
        chk("R3 ie after trap", 32'(ie_o), 2);
        chk("R1 pulse end", 32'(redirect_o), 1);
        step();
        chk("R1 single pulse", 32'({redirect_o, rf_we_o}), 0);
        ret(5'd30);
        chk("R6 ret30", 32'(ie_o), 1);
    endtask

    task automatic t_breakpoint();
        trap(0, 0, 0, 1, 32'h0000_2004);
        chk("R2 link", 32'({rf_we_o, rf_waddr_o}), 32'({1'b1, 5'd31}));
        chk("R2 saved pc", rf_wdata_o, 32'h0000_2004);
        chk("R5 bp vector", redirect_pc_o, 32'hABCD_EF20);
        chk("R4 ie after bp", 32'(ie_o), 4);
        ret(5'd5);
        chk("R6 other reg", 32'(ie_o), 4);
        ret(5'd31);
        chk("R6 ret31", 32'(ie_o), 1);
    endtask

    task automatic t_divzero_disabled();
        csr_wr(2'd0, 32'h0);
        trap(0, 1, 0, 0, 32'h0000_0040);
        chk("R5 dz vector", redirect_pc_o, 32'h1234_56A0);
        chk("R3 ie stays off", 32'(ie_o), 0);
    endtask

    task automatic t_priority();
        trap(1, 1, 1, 1, 32'h10);
        chk("R10 dbe wins", 32'(exc_id_o), 4);
        chk("R5 dbe vector", redirect_pc_o, 32'h1234_5680);
        trap(0, 1, 1, 1, 32'h14);
        chk("R10 dz wins", 32'(exc_id_o), 5);
        chk("R1 dz link", 32'(rf_waddr_o), 30);
        trap(0, 0, 1, 1, 32'h18);
        chk("R10 sc over bp", 32'(exc_id_o), 7);
    endtask

    task automatic t_pending();
        irq_set_i = 32'h0000_F0F1;
        step();
        chk("R8 set", ip_o, 32'h0000_F0F1);
        csr_wr(2'd1, 32'h0000_00F0);
        chk("R8 w1c", ip_o, 32'h0000_F001);
        csr_wr(2'd1, 32'h0);
        chk("R8 zero write", ip_o, 32'h0000_F001);
        irq_set_i = 32'h1; csr_we_i = 1; csr_sel_i = 2'd1; csr_wdata_i = 32'h1;
        step();
        chk("R8 set wins", ip_o, 32'h0000_F001);
    endtask

    task automatic t_collisions();
        csr_wr(2'd0, 32'h1);
        trap_sc_i = 1; trap_pc_i = 32'h80; csr_we_i = 1; csr_sel_i = 2'd2;
        csr_wdata_i = 32'hFFFF_FF00; ret_i = 1; ret_reg_i = 5'd30;
        step();
        chk("R11 eba kept", eba_o, 32'h1234_5600);
        chk("R11 trap over ret", 32'(ie_o), 2);
        ret_i = 1; ret_reg_i = 5'd30; csr_we_i = 1; csr_sel_i = 2'd0; csr_wdata_i = 32'h4;
        step();
        chk("R11 ret over csr", 32'(ie_o), 1);
    endtask

    initial begin
        idle_inputs();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_csr_writes();
        t_syscall_and_return();
        t_breakpoint();
        t_divzero_disabled();
        t_priority();
        t_pending();
        t_collisions();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule